// File: doc/BRIEF.md
# Programmable Output Clock Divider

This block turns a fast source clock into a slower output clock whose period is an integer number N of source cycles. N comes from an 11-bit divide field. The field is decoded before use: the two lowest codes both mean divide-by-two, codes two to five give exactly that ratio, and from six upward bit 0 is dropped so the ratio is always even. The largest ratio is 2046.

Every ratio gives an output that is high for half of its period. Even ratios need only the rising edge of the source clock. The two odd ratios, 3 and 5, add a stage clocked on the falling edge that stretches the high phase by half a source cycle. The field may be rewritten at any time. A new value is sampled only on the source edge that starts an output period, so the period in progress always finishes at its old length and no short pulse appears.

An active-low reset forces the output low at once and clears the period counter. The first output period begins on the first rising source edge after reset is released, using the field value present at that edge.

Top module: `outclk_divider`

## Requirements
- R1: Field codes 0 and 1 both give a divide ratio of 2.
- R2: Field codes 2, 3, 4 and 5 give ratios equal to the code; 3 and 5 are the only odd ratios.
- R3: For field codes 6 and above the ratio is the code with bit 0 forced to 0, so codes 2046 and 2047 both give 2046.
- R4: While the field holds a ratio N, each output period lasts exactly N source clock periods, measured from rising output edge to rising output edge.
- R5: For an even ratio N the output stays high for exactly N/2 source clock periods in each output period.
- R6: For the odd ratios 3 and 5 the output stays high for exactly N/2 source clock periods (1.5 or 2.5), rising on a rising source edge and falling on a falling source edge.
- R7: A field change takes effect only at the next output period start; the period in progress completes at the old ratio, and the output rises only at a period start.
- R8: While rst_n is low the output is low, and asserting rst_n low drives the output low without waiting for a source edge.
- R9: After reset is released, the output rises on the first rising source edge, and that first period uses the field value present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast source clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_field | input | 11 | Divide field, decoded into the ratio N |
| clk_out | output | 1 | Divided clock, half high and half low in each period |

## Verification
The assertions assume that the divide field is stable around each rising source edge and that reset is only released away from a rising edge. Under that assumption the loaded ratio stays in the decoded range and is even above 5, the counter stays below it, and the output rises only when the counter restarts. The bench changes the field and releases reset only on falling source edges. Its field values are a mix of a directed sweep over every code up to 65, the extreme codes, and codes drawn from $urandom with a fixed seed, some from the small-code range and some from the full range.

// File: rtl/odiv_pkg.sv
package odiv_pkg;
   // Highest field code that is passed through unchanged as a ratio.
   localparam int unsigned EXACT_LIMIT = 5;
   // Lowest ratio the divider produces.
   localparam int unsigned MIN_RATIO   = 2;

   typedef enum logic {
      DUTY_EVEN = 1'b0,
      DUTY_ODD  = 1'b1
   } duty_e;
endpackage

// File: rtl/odiv_decode.sv
module odiv_decode
   import odiv_pkg::*;
#(
   parameter int unsigned FIELD_W    = 11,
   parameter bit          ENABLE_ODD = 1'b1
) (
   input  logic [FIELD_W-1:0] field,
   output logic [FIELD_W-1:0] ratio,
   output duty_e              duty
);
   localparam logic [FIELD_W-1:0] LOW_CODE   = FIELD_W'(MIN_RATIO);
   localparam logic [FIELD_W-1:0] EXACT_CODE = FIELD_W'(EXACT_LIMIT);

   logic [FIELD_W-1:0] raw_ratio;

   always_comb begin
      if (field < LOW_CODE)
         raw_ratio = LOW_CODE;
      else if (field <= EXACT_CODE)
         raw_ratio = field;
      else
         raw_ratio = {field[FIELD_W-1:1], 1'b0};
   end

   generate
      if (ENABLE_ODD) begin : g_odd_kept
         assign ratio = raw_ratio;
      end else begin : g_odd_rounded
         assign ratio = {raw_ratio[FIELD_W-1:1], 1'b0};
      end
   endgenerate

   assign duty = ratio[0] ? DUTY_ODD : DUTY_EVEN;
endmodule

// File: rtl/odiv_seq.sv
module odiv_seq
   import odiv_pkg::*;
#(
   parameter int unsigned FIELD_W = 11
) (
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] ratio_in,
   input  duty_e              duty_in,
   output logic [FIELD_W-1:0] ratio_q,
   output logic [FIELD_W-1:0] cnt_q,
   output logic               run_q,
   output duty_e              duty_q,
   output logic               hi_q
);
   localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

   logic [FIELD_W-1:0] half;
   logic [FIELD_W-1:0] cnt_nx;
   logic               last;

   assign half   = ratio_q >> 1;
   assign cnt_nx = cnt_q + ONE;
   assign last   = (cnt_q == ratio_q - ONE);

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ratio_q <= FIELD_W'(MIN_RATIO);
         duty_q  <= DUTY_EVEN;
         cnt_q   <= '0;
         hi_q    <= 1'b0;
      end else if (!run_q || last) begin
         // period start: sample the new ratio here and nowhere else
         run_q   <= 1'b1;
         ratio_q <= ratio_in;
         duty_q  <= duty_in;
         cnt_q   <= '0;
         hi_q    <= 1'b1;
      end else begin
         cnt_q   <= cnt_nx;
         hi_q    <= (cnt_nx < half);
      end
   end
endmodule

// File: rtl/odiv_halfstage.sv
module odiv_halfstage
   import odiv_pkg::*;
#(
   parameter bit ENABLE_ODD = 1'b1
) (
   input  logic  clk_in,
   input  logic  rst_n,
   input  logic  hi_q,
   input  duty_e duty_q,
   output logic  ext_q
);
   generate
      if (ENABLE_ODD) begin : g_fall_stage
         always_ff @(negedge clk_in or negedge rst_n) begin
            if (!rst_n)
               ext_q <= 1'b0;
            else
               ext_q <= hi_q && (duty_q == DUTY_ODD);
         end
      end else begin : g_no_stage
         assign ext_q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/outclk_divider.sv
module outclk_divider
   import odiv_pkg::*;
#(
   parameter int unsigned FIELD_W    = 11,
   parameter bit          ENABLE_ODD = 1'b1
) (
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] div_field,
   output logic               clk_out
);
   generate
      if (FIELD_W < 3 || FIELD_W > 24) begin : g_bad_width
         $error("outclk_divider: FIELD_W must lie in 3..24");
      end
   endgenerate

   logic [FIELD_W-1:0] dec_ratio;
   duty_e              dec_duty;
   logic [FIELD_W-1:0] ratio_q;
   logic [FIELD_W-1:0] cnt_q;
   logic               run_q;
   duty_e              duty_q;
   logic               hi_q;
   logic               ext_q;

   odiv_decode #(.FIELD_W(FIELD_W), .ENABLE_ODD(ENABLE_ODD)) u_decode (
      .field (div_field),
      .ratio (dec_ratio),
      .duty  (dec_duty)
   );

   odiv_seq #(.FIELD_W(FIELD_W)) u_seq (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .ratio_in (dec_ratio),
      .duty_in  (dec_duty),
      .ratio_q  (ratio_q),
      .cnt_q    (cnt_q),
      .run_q    (run_q),
      .duty_q   (duty_q),
      .hi_q     (hi_q)
   );

   odiv_halfstage #(.ENABLE_ODD(ENABLE_ODD)) u_half (
      .clk_in (clk_in),
      .rst_n  (rst_n),
      .hi_q   (hi_q),
      .duty_q (duty_q),
      .ext_q  (ext_q)
   );

   assign clk_out = hi_q | ext_q;
endmodule

// File: rtl/odiv_checker.sv
module odiv_checker #(
   parameter int unsigned FIELD_W = 11
) (
   input logic               clk_in,
   input logic               rst_n,
   input logic               clk_out,
   input logic [FIELD_W-1:0] ratio_q,
   input logic [FIELD_W-1:0] cnt_q,
   input logic               run_q
);
   localparam logic [FIELD_W-1:0] TOP_RATIO = {{(FIELD_W-1){1'b1}}, 1'b0};

   AST_RATIO_RANGE: assert property (@(posedge clk_in) disable iff (!rst_n)
      (ratio_q >= FIELD_W'(2)) && (ratio_q <= TOP_RATIO))
      else $error("ratio out of range");                             // R1

   AST_EVEN_ABOVE_FIVE: assert property (@(posedge clk_in) disable iff (!rst_n)
      (ratio_q > FIELD_W'(5)) |-> !ratio_q[0])
      else $error("odd ratio above five");                           // R3

   AST_CNT_BELOW_RATIO: assert property (@(posedge clk_in) disable iff (!rst_n)
      cnt_q < ratio_q)
      else $error("counter beyond ratio");                           // R4

   AST_RATIO_HELD_MID_PERIOD: assert property (@(posedge clk_in) disable iff (!rst_n)
      (run_q && cnt_q != '0) |-> $stable(ratio_q))
      else $error("ratio changed inside a period");                  // R7

   AST_RISE_AT_PERIOD_START: assert property (@(posedge clk_in) disable iff (!rst_n)
      $rose(clk_out) |-> (cnt_q == '0))
      else $error("output rose away from a period start");           // R7

   always @(negedge clk_in) begin
      if (rst_n === 1'b0) begin
         AST_LOW_IN_RESET: assert (clk_out == 1'b0)
            else $error("output high during reset");                  // R8
      end
   end
endmodule

bind outclk_divider odiv_checker #(.FIELD_W(FIELD_W)) u_chk (
   .clk_in  (clk_in),
   .rst_n   (rst_n),
   .clk_out (clk_out),
   .ratio_q (ratio_q),
   .cnt_q   (cnt_q),
   .run_q   (run_q)
);

// File: tb/outclk_divider_tb.sv
module outclk_divider_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int FW = 11;

   logic          clk_in = 1'b0;
   logic          rst_n  = 1'b0;
   logic [FW-1:0] div_field = '0;
   logic          clk_out;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;
   time tr, th, tp, trel;
   int  cur_ratio;
   int  cur_field;
   int  seed_dummy;

   always #10 clk_in = ~clk_in;

   outclk_divider #(.FIELD_W(FW)) u_dut (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .div_field (div_field),
      .clk_out   (clk_out)
   );

   function automatic int exp_ratio(input int f);
      if (f < 2)      return 2;
      else if (f < 6) return f;
      else            return f - (f % 2);
   endfunction

   function automatic string cat_tag(input int f);
      if (f < 2)      return "R1";
      else if (f < 6) return "R2";
      else            return "R3";
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Sits at a rising output edge; writes the next field a half source cycle
   // later, then measures the period in progress, which must keep the old ratio.
   task automatic step(input int nf);
      @(negedge clk_in);
      div_field = FW'(nf);
      @(negedge clk_out);
      th = $time;
      @(posedge clk_out);
      tp = $time;
      chk($sformatf("%s high f=%0d", (cur_ratio % 2 == 0) ? "R5" : "R6", cur_field),
          longint'(th - tr), 10 * cur_ratio);
      chk($sformatf("R4/R7/%s period f=%0d", cat_tag(cur_field), cur_field),
          longint'(tp - tr), 20 * cur_ratio);
      tr        = tp;
      cur_field = nf;
      cur_ratio = exp_ratio(nf);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R4 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end

   initial begin
      seed_dummy = $urandom(32'd4242);
      div_field  = FW'(4);
      repeat (3) @(negedge clk_in);
      chk("R8 output low in reset", clk_out, 0);

      // R9: release on a falling edge, rise expected on the next rising edge
      @(negedge clk_in);
      rst_n = 1'b1;
      trel  = $time;
      @(posedge clk_out);
      tr = $time;
      chk("R9 first rise delay", longint'(tr - trel), 10);
      cur_field = 4;
      cur_ratio = exp_ratio(4);

      // directed sweep over every small code: covers R1, R2 and even ratios to 64
      for (int f = 0; f <= 65; f++) step(f);

      // extreme codes of R3
      step(2047);
      step(2046);
      step(7);
      step(3);
      step(5);

      // constrained random codes
      for (int i = 0; i < 24; i++) begin
         int f;
         if ($urandom_range(3, 0) == 0) f = int'($urandom_range(7, 0));
         else                           f = int'($urandom_range(2047, 0));
         step(f);
      end
      step(1);

      // R8: asynchronous reset while the output is high
      #1;
      chk("R8 output high before reset", clk_out, 1);
      rst_n = 1'b0;
      #1;
      chk("R8 output forced low", clk_out, 0);
      div_field = FW'(5);
      repeat (3) begin
         @(negedge clk_in);
         chk("R8 output held low", clk_out, 0);
      end

      // R9: first period after release uses the field present at release
      @(negedge clk_in);
      rst_n = 1'b1;
      trel  = $time;
      @(posedge clk_out);
      tr = $time;
      chk("R9 first rise after second release", longint'(tr - trel), 10);
      cur_field = 5;
      cur_ratio = 5;
      step(0);
      step(6);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end
endmodule